// File: doc/BRIEF.md
# Two-Channel Tile Address Counter with Circular Input Wrap

This block generates addresses for a tile loader. It holds two counter channels. Channel 0 faces the input (memory) side and channel 1 faces the output (register-file) side. Each channel holds four dimension counters, X, Y, Z and W, plus saved copies of Y and Z that a restore command can copy back. Commands load counters absolutely, add signed deltas to them, or restore the saved copies. A transfer strobe applies small per-transfer increments that come from one of four modifier slots.

Three results are produced combinationally from the counters and the configuration inputs. The first is the number of datums in a transfer. The second is the output register-file address, built from a base and three strides and scaled for the output datum size. The third is the input memory address in 16-byte units. That address skips the tile header and wraps back inside a circular buffer when it passes a limit.

A small context counter steps round-robin over 1, 2, 4 or 8 contexts on each transfer that asks for it.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset every counter, every saved copy and the context index are zero, so the datum count reads 1.
- R2: A set command (`set_sel`=0 writes X/Y, `set_sel`=1 writes Z/W) writes only the fields whose `set_mask` bit is 1. Mask bit k takes lane k of `set_data`: bit 0 → ch0 first field, bit 1 → ch0 second field, bit 2 → ch1 first field, bit 3 → ch1 second field. Setting Y or Z also loads that field's saved copy.
- R3: `datum_cnt` equals (ch1 X + 1) − ch0 X, modulo 2^16.
- R4: An increment command adds the signed lanes of `inc_data` to X/Y (`inc_sel`=0) or Z/W (`inc_sel`=1) of both channels. Lanes are placed as in R2, and each sum wraps modulo 2^16.
- R5: A restore command copies the saved Y (`cr_sel`=0) or saved Z (`cr_sel`=1) into the current counter of each channel whose `cr_chmask` bit is set. Other channels are unchanged.
- R6: A transfer selects 8-bit slot `xfer_slot` of `amod_slots` (slot k at bits 8k+7:8k). Within the slot, bits [1:0] are added to ch0 Y, [3:2] to ch0 Z, [5:4] to ch1 Y and [7:6] to ch1 Z. X and W are not changed.
- R7: When commands coincide, only the highest-priority one acts, in the order set, increment, restore, transfer auto-increment. With no command, all counters hold.
- R8: `out_addr` = `out_base` + ch1 Y·`y_stride` + ch1 Z·`z_stride` + ch1 W·`w_stride`, shifted right by 1 when `out_fmt`=1 (16-bit), by 2 when `out_fmt`=2 (32-bit), and not shifted for codes 0 and 3.
- R9: `in_addr` = `in_base` + `in_offset` + 1 + `digest_size`, in 16-byte units. When this value is strictly greater than `in_limit`, `fifo_size` is subtracted from it once.
- R10: On a transfer with `xfer_ctx_auto`=1, `ctx_id` becomes (`ctx_id`+1) mod 2^`ctx_log2`. `ctx_clr` forces it to 0 and overrides the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_vld | input | 1 | Set command strobe |
| set_sel | input | 1 | 0: X/Y pair, 1: Z/W pair |
| set_mask | input | 4 | Per-lane write enable |
| set_data | input | 4*CW | Four set values, lane 0 lowest |
| inc_vld | input | 1 | Increment command strobe |
| inc_sel | input | 1 | 0: X/Y pair, 1: Z/W pair |
| inc_data | input | 4*CW | Four signed deltas |
| cr_vld | input | 1 | Restore command strobe |
| cr_sel | input | 1 | 0: restore Y, 1: restore Z |
| cr_chmask | input | 2 | Channels that restore |
| xfer_vld | input | 1 | Transfer strobe |
| xfer_slot | input | 2 | Modifier slot index |
| xfer_ctx_auto | input | 1 | Advance context on this transfer |
| amod_slots | input | 32 | Four 8-bit modifier slots |
| ctx_log2 | input | 2 | log2 of context count |
| ctx_clr | input | 1 | Clear context index |
| out_base | input | OAW | Output address base (datums) |
| y_stride | input | CW | Output Y stride |
| z_stride | input | CW | Output Z stride |
| w_stride | input | CW | Output W stride |
| out_fmt | input | 2 | Output datum size code |
| in_base | input | IAW | Input base, 16-byte units |
| in_offset | input | CW | Input offset, 16-byte units |
| digest_size | input | DGW | Extra header lines |
| in_limit | input | IAW | Wrap limit, 16-byte units |
| fifo_size | input | IAW | Circular region size, 16-byte units |
| ch0_x | output | CW | Channel 0 X |
| ch0_y | output | CW | Channel 0 Y |
| ch0_z | output | CW | Channel 0 Z |
| ch0_w | output | CW | Channel 0 W |
| ch1_x | output | CW | Channel 1 X |
| ch1_y | output | CW | Channel 1 Y |
| ch1_z | output | CW | Channel 1 Z |
| ch1_w | output | CW | Channel 1 W |
| datum_cnt | output | CW | Datums per transfer |
| out_addr | output | OAW | Output register-file address |
| in_addr | output | IAW | Wrapped input address |
| ctx_id | output | 3 | Current context index |

## Verification
The output address is driven through a table of counter and stride combinations. Each stride is isolated alone and then combined with the others, so a swapped stride or a missing term shows up. The same sums are repeated under the 16-bit and 32-bit shift codes, which exposes a wrong shift amount, and a Y value at the top of its range exposes truncation of the products. Counter commands are tried with partial masks, negative deltas that wrap, and restores limited to one channel, which separates mask decoding from lane placement. Coincident commands then show the priority order, and input addresses on both sides of the limit, including the exact limit, pin down the strict comparison.

// File: rtl/tile_addr_gen_pkg.sv
package tile_addr_gen_pkg;

  typedef enum logic [1:0] {
    OFMT_B8  = 2'd0,
    OFMT_B16 = 2'd1,
    OFMT_B32 = 2'd2,
    OFMT_RSV = 2'd3
  } out_fmt_e;

  typedef struct packed {
    logic [1:0] c1z;
    logic [1:0] c1y;
    logic [1:0] c0z;
    logic [1:0] c0y;
  } amod_t;

  localparam int unsigned CHANNELS = 2;
  localparam int unsigned LANES    = 4;

endpackage

// File: rtl/tile_addr_chan.sv
module tile_addr_chan #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          set_sel,
  input  logic [1:0]    set_m,
  input  logic [CW-1:0] set_a,
  input  logic [CW-1:0] set_b,
  input  logic          inc_en,
  input  logic          inc_sel,
  input  logic [CW-1:0] inc_a,
  input  logic [CW-1:0] inc_b,
  input  logic          cr_en,
  input  logic          cr_sel,
  input  logic          auto_en,
  input  logic [1:0]    auto_dy,
  input  logic [1:0]    auto_dz,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y,
  output logic [CW-1:0] z,
  output logic [CW-1:0] w
);

  logic [CW-1:0] x_q, y_q, z_q, w_q, ys_q, zs_q;
  logic [CW-1:0] x_n, y_n, z_n, w_n, ys_n, zs_n;
  logic          upd;

  assign upd = set_en | inc_en | cr_en | auto_en;

  always_comb begin
    x_n  = x_q;
    y_n  = y_q;
    z_n  = z_q;
    w_n  = w_q;
    ys_n = ys_q;
    zs_n = zs_q;
    if (set_en) begin
      if (!set_sel) begin
        if (set_m[0]) x_n = set_a;
        if (set_m[1]) begin
          y_n  = set_b;
          ys_n = set_b;
        end
      end else begin
        if (set_m[0]) begin
          z_n  = set_a;
          zs_n = set_a;
        end
        if (set_m[1]) w_n = set_b;
      end
    end else if (inc_en) begin
      if (!inc_sel) begin
        x_n = x_q + inc_a;
        y_n = y_q + inc_b;
      end else begin
        z_n = z_q + inc_a;
        w_n = w_q + inc_b;
      end
    end else if (cr_en) begin
      if (!cr_sel) y_n = ys_q;
      else         z_n = zs_q;
    end else if (auto_en) begin
      y_n = y_q + CW'(auto_dy);
      z_n = z_q + CW'(auto_dz);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      z_q  <= '0;
      w_q  <= '0;
      ys_q <= '0;
      zs_q <= '0;
    end else if (upd) begin
      x_q  <= x_n;
      y_q  <= y_n;
      z_q  <= z_n;
      w_q  <= w_n;
      ys_q <= ys_n;
      zs_q <= zs_n;
    end
  end

  assign x = x_q;
  assign y = y_q;
  assign z = z_q;
  assign w = w_q;

endmodule

// File: rtl/tile_out_addr.sv
module tile_out_addr
  import tile_addr_gen_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned OAW = 32
) (
  input  logic [CW-1:0]  c0_x,
  input  logic [CW-1:0]  c1_x,
  input  logic [CW-1:0]  c1_y,
  input  logic [CW-1:0]  c1_z,
  input  logic [CW-1:0]  c1_w,
  input  logic [OAW-1:0] base,
  input  logic [CW-1:0]  ys,
  input  logic [CW-1:0]  zs,
  input  logic [CW-1:0]  ws,
  input  logic [1:0]     fmt,
  output logic [CW-1:0]  count,
  output logic [OAW-1:0] addr
);

  logic [OAW-1:0] term_y, term_z, term_w, sum;

  assign count  = c1_x + CW'(1) - c0_x;
  assign term_y = OAW'(c1_y) * OAW'(ys);
  assign term_z = OAW'(c1_z) * OAW'(zs);
  assign term_w = OAW'(c1_w) * OAW'(ws);
  assign sum    = base + term_y + term_z + term_w;

  always_comb begin
    unique case (out_fmt_e'(fmt))
      OFMT_B16: addr = sum >> 1;
      OFMT_B32: addr = sum >> 2;
      default:  addr = sum;
    endcase
  end

endmodule

// File: rtl/tile_in_addr.sv
module tile_in_addr #(
  parameter int unsigned CW  = 16,
  parameter int unsigned IAW = 24,
  parameter int unsigned DGW = 4
) (
  input  logic [IAW-1:0] base,
  input  logic [CW-1:0]  offset,
  input  logic [DGW-1:0] digest,
  input  logic [IAW-1:0] limit,
  input  logic [IAW-1:0] fifo,
  output logic [IAW-1:0] addr
);

  logic [IAW-1:0] raw;

  assign raw  = base + IAW'(offset) + IAW'(digest) + IAW'(1);
  assign addr = (raw > limit) ? (raw - fifo) : raw;

endmodule

// File: rtl/tile_ctx_ctr.sv
module tile_ctx_ctr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       clr,
  input  logic [1:0] log2n,
  output logic [2:0] ctx
);

  logic [2:0] ctx_q, ctx_n, wrap_mask;
  logic       en;

  assign wrap_mask = 3'((4'd1 << log2n) - 4'd1);
  assign en        = adv | clr;

  always_comb begin
    if (clr) ctx_n = '0;
    else     ctx_n = (ctx_q + 3'd1) & wrap_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctx_q <= '0;
    else if (en) ctx_q <= ctx_n;
  end

  assign ctx = ctx_q;

endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_addr_gen_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned OAW = 32,
  parameter int unsigned IAW = 24,
  parameter int unsigned DGW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic              set_sel,
  input  logic [3:0]        set_mask,
  input  logic [4*CW-1:0]   set_data,
  input  logic              inc_vld,
  input  logic              inc_sel,
  input  logic [4*CW-1:0]   inc_data,
  input  logic              cr_vld,
  input  logic              cr_sel,
  input  logic [1:0]        cr_chmask,
  input  logic              xfer_vld,
  input  logic [1:0]        xfer_slot,
  input  logic              xfer_ctx_auto,
  input  logic [31:0]       amod_slots,
  input  logic [1:0]        ctx_log2,
  input  logic              ctx_clr,
  input  logic [OAW-1:0]    out_base,
  input  logic [CW-1:0]     y_stride,
  input  logic [CW-1:0]     z_stride,
  input  logic [CW-1:0]     w_stride,
  input  logic [1:0]        out_fmt,
  input  logic [IAW-1:0]    in_base,
  input  logic [CW-1:0]     in_offset,
  input  logic [DGW-1:0]    digest_size,
  input  logic [IAW-1:0]    in_limit,
  input  logic [IAW-1:0]    fifo_size,
  output logic [CW-1:0]     ch0_x,
  output logic [CW-1:0]     ch0_y,
  output logic [CW-1:0]     ch0_z,
  output logic [CW-1:0]     ch0_w,
  output logic [CW-1:0]     ch1_x,
  output logic [CW-1:0]     ch1_y,
  output logic [CW-1:0]     ch1_z,
  output logic [CW-1:0]     ch1_w,
  output logic [CW-1:0]     datum_cnt,
  output logic [OAW-1:0]    out_addr,
  output logic [IAW-1:0]    in_addr,
  output logic [2:0]        ctx_id
);

  localparam int unsigned NCH = CHANNELS;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  // command priority: set > increment > restore > transfer auto-increment
  logic set_en, inc_en, cr_any, auto_en;
  assign set_en  = set_vld;
  assign inc_en  = inc_vld & ~set_vld;
  assign cr_any  = cr_vld & ~set_vld & ~inc_vld;
  assign auto_en = xfer_vld & ~set_vld & ~inc_vld & ~cr_vld;

  amod_t mod_sel;
  assign mod_sel = amod_t'(amod_slots[8*xfer_slot +: 8]);

  logic [CW-1:0] cx [NCH];
  logic [CW-1:0] cy [NCH];
  logic [CW-1:0] cz [NCH];
  logic [CW-1:0] cwv[NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [1:0] dy, dz;
    assign dy = (i == 0) ? mod_sel.c0y : mod_sel.c1y;
    assign dz = (i == 0) ? mod_sel.c0z : mod_sel.c1z;

    tile_addr_chan #(.CW(CW)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .set_en  (set_en),
      .set_sel (set_sel),
      .set_m   (set_mask[2*i +: 2]),
      .set_a   (set_data[(2*i)*CW +: CW]),
      .set_b   (set_data[(2*i+1)*CW +: CW]),
      .inc_en  (inc_en),
      .inc_sel (inc_sel),
      .inc_a   (inc_data[(2*i)*CW +: CW]),
      .inc_b   (inc_data[(2*i+1)*CW +: CW]),
      .cr_en   (cr_any & cr_chmask[i]),
      .cr_sel  (cr_sel),
      .auto_en (auto_en),
      .auto_dy (dy),
      .auto_dz (dz),
      .x       (cx[i]),
      .y       (cy[i]),
      .z       (cz[i]),
      .w       (cwv[i])
    );
  end

  assign ch0_x = cx[0];
  assign ch0_y = cy[0];
  assign ch0_z = cz[0];
  assign ch0_w = cwv[0];
  assign ch1_x = cx[1];
  assign ch1_y = cy[1];
  assign ch1_z = cz[1];
  assign ch1_w = cwv[1];

  tile_out_addr #(.CW(CW), .OAW(OAW)) out_i (
    .c0_x  (cx[0]),
    .c1_x  (cx[1]),
    .c1_y  (cy[1]),
    .c1_z  (cz[1]),
    .c1_w  (cwv[1]),
    .base  (out_base),
    .ys    (y_stride),
    .zs    (z_stride),
    .ws    (w_stride),
    .fmt   (out_fmt),
    .count (datum_cnt),
    .addr  (out_addr)
  );

  tile_in_addr #(.CW(CW), .IAW(IAW), .DGW(DGW)) in_i (
    .base   (in_base),
    .offset (in_offset),
    .digest (digest_size),
    .limit  (in_limit),
    .fifo   (fifo_size),
    .addr   (in_addr)
  );

  tile_ctx_ctr ctx_i (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .adv   (xfer_vld & xfer_ctx_auto),
    .clr   (ctx_clr),
    .log2n (ctx_log2),
    .ctx   (ctx_id)
  );

endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
  parameter int unsigned CW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            set_vld,
  input logic            set_sel,
  input logic [3:0]      set_mask,
  input logic [4*CW-1:0] set_data,
  input logic            inc_vld,
  input logic            inc_sel,
  input logic [4*CW-1:0] inc_data,
  input logic            cr_vld,
  input logic            xfer_vld,
  input logic            ctx_clr,
  input logic [CW-1:0]   ch0_x,
  input logic [CW-1:0]   ch0_w,
  input logic [CW-1:0]   ch1_y,
  input logic [2:0]      ctx_id
);

  assert_set_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && !set_sel && set_mask[0]) |=> (ch0_x == $past(set_data[CW-1:0])));

  assert_inc_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_vld && !set_vld && !inc_sel) |=>
      (ch0_x == CW'($past(ch0_x) + $past(inc_data[CW-1:0]))));

  assert_auto_keeps_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_vld && !set_vld && !inc_vld && !cr_vld) |=> ($stable(ch0_x) && $stable(ch0_w)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_vld && !inc_vld && !cr_vld && !xfer_vld) |=> ($stable(ch0_x) && $stable(ch1_y)));

  assert_ctx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clr |=> (ctx_id == 3'd0));

endmodule

bind tile_addr_gen tile_addr_gen_chk #(.CW(CW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .set_vld  (set_vld),
  .set_sel  (set_sel),
  .set_mask (set_mask),
  .set_data (set_data),
  .inc_vld  (inc_vld),
  .inc_sel  (inc_sel),
  .inc_data (inc_data),
  .cr_vld   (cr_vld),
  .xfer_vld (xfer_vld),
  .ctx_clr  (ctx_clr),
  .ch0_x    (ch0_x),
  .ch0_w    (ch0_w),
  .ch1_y    (ch1_y),
  .ctx_id   (ctx_id)
);

// File: tb/tile_addr_gen_tb_top.sv
module tile_addr_gen_tb_top;

  localparam int CW  = 16;
  localparam int OAW = 32;
  localparam int IAW = 24;
  localparam int DGW = 4;

  // columns: ch1_y, ch1_z, ch1_w, base, ys, zs, ws, fmt, expected out_addr
  localparam logic [31:0] OUT_TBL [8][9] = '{
    '{32'd1,      32'd0, 32'd0, 32'd0,   32'd16, 32'd0,   32'd0,    32'd0, 32'd16},
    '{32'd2,      32'd1, 32'd0, 32'd100, 32'd16, 32'd256, 32'd0,    32'd0, 32'd388},
    '{32'd3,      32'd2, 32'd1, 32'd0,   32'd16, 32'd64,  32'd1024, 32'd0, 32'd1200},
    '{32'd2,      32'd1, 32'd0, 32'd100, 32'd16, 32'd256, 32'd0,    32'd1, 32'd194},
    '{32'd3,      32'd2, 32'd1, 32'd0,   32'd16, 32'd64,  32'd1024, 32'd2, 32'd300},
    '{32'd5,      32'd0, 32'd0, 32'd7,   32'd1,  32'd0,   32'd0,    32'd1, 32'd6},
    '{32'd65535,  32'd0, 32'd0, 32'd0,   32'd2,  32'd0,   32'd0,    32'd0, 32'd131070},
    '{32'd4,      32'd3, 32'd2, 32'd10,  32'd10, 32'd100, 32'd1000, 32'd3, 32'd2350}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic set_vld, set_sel, inc_vld, inc_sel, cr_vld, cr_sel;
  logic xfer_vld, xfer_ctx_auto, ctx_clr;
  logic [3:0] set_mask;
  logic [4*CW-1:0] set_data, inc_data;
  logic [1:0] cr_chmask, xfer_slot, ctx_log2, out_fmt;
  logic [31:0] amod_slots;
  logic [OAW-1:0] out_base;
  logic [CW-1:0] y_stride, z_stride, w_stride, in_offset;
  logic [IAW-1:0] in_base, in_limit, fifo_size;
  logic [DGW-1:0] digest_size;
  logic [CW-1:0] ch0_x, ch0_y, ch0_z, ch0_w, ch1_x, ch1_y, ch1_z, ch1_w, datum_cnt;
  logic [OAW-1:0] out_addr;
  logic [IAW-1:0] in_addr;
  logic [2:0] ctx_id;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tile_addr_gen #(.CW(CW), .OAW(OAW), .IAW(IAW), .DGW(DGW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .set_vld(set_vld), .set_sel(set_sel), .set_mask(set_mask), .set_data(set_data),
    .inc_vld(inc_vld), .inc_sel(inc_sel), .inc_data(inc_data),
    .cr_vld(cr_vld), .cr_sel(cr_sel), .cr_chmask(cr_chmask),
    .xfer_vld(xfer_vld), .xfer_slot(xfer_slot), .xfer_ctx_auto(xfer_ctx_auto),
    .amod_slots(amod_slots), .ctx_log2(ctx_log2), .ctx_clr(ctx_clr),
    .out_base(out_base), .y_stride(y_stride), .z_stride(z_stride), .w_stride(w_stride),
    .out_fmt(out_fmt), .in_base(in_base), .in_offset(in_offset), .digest_size(digest_size),
    .in_limit(in_limit), .fifo_size(fifo_size),
    .ch0_x(ch0_x), .ch0_y(ch0_y), .ch0_z(ch0_z), .ch0_w(ch0_w),
    .ch1_x(ch1_x), .ch1_y(ch1_y), .ch1_z(ch1_z), .ch1_w(ch1_w),
    .datum_cnt(datum_cnt), .out_addr(out_addr), .in_addr(in_addr), .ctx_id(ctx_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    set_vld = 1'b0; inc_vld = 1'b0; cr_vld = 1'b0; xfer_vld = 1'b0; ctx_clr = 1'b0;
  endtask

  task automatic do_set(input logic sel, input logic [3:0] m,
                        input logic [15:0] v0, v1, v2, v3);
    set_vld = 1'b1; set_sel = sel; set_mask = m; set_data = {v3, v2, v1, v0};
    tick();
  endtask

  task automatic do_inc(input logic sel, input logic [15:0] d0, d1, d2, d3);
    inc_vld = 1'b1; inc_sel = sel; inc_data = {d3, d2, d1, d0};
    tick();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    set_vld = 0; set_sel = 0; set_mask = 0; set_data = '0;
    inc_vld = 0; inc_sel = 0; inc_data = '0;
    cr_vld = 0; cr_sel = 0; cr_chmask = 0;
    xfer_vld = 0; xfer_slot = 0; xfer_ctx_auto = 0; ctx_clr = 0;
    amod_slots = 32'h00E4_0000; ctx_log2 = 2'd0;
    out_base = '0; y_stride = '0; z_stride = '0; w_stride = '0; out_fmt = 2'd0;
    in_base = '0; in_offset = '0; digest_size = '0; in_limit = 24'hFFFFFF; fifo_size = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    check("R1 ch0_x", ch0_x, 0);
    check("R1 ch1_y", ch1_y, 0);
    check("R1 ch1_w", ch1_w, 0);
    check("R1 ctx_id", ctx_id, 0);
    check("R1/R3 datum_cnt", datum_cnt, 1);

    // R2 masked set
    do_set(1'b0, 4'b0101, 16'd5, 16'd9, 16'd20, 16'd33);
    check("R2 ch0_x", ch0_x, 5);
    check("R2 ch0_y masked", ch0_y, 0);
    check("R2 ch1_x", ch1_x, 20);
    check("R2 ch1_y masked", ch1_y, 0);
    check("R3 count", datum_cnt, 16);
    do_set(1'b0, 4'b0001, 16'd21, 16'd0, 16'd0, 16'd0);
    check("R3 zero count", datum_cnt, 0);

    // R4 signed increments with wrap
    do_inc(1'b0, 16'hFFFF, 16'd3, 16'd2, 16'd0);
    check("R4 ch0_x", ch0_x, 20);
    check("R4 ch0_y", ch0_y, 3);
    check("R4 ch1_x", ch1_x, 22);
    do_set(1'b0, 4'b0001, 16'd0, 16'd0, 16'd0, 16'd0);
    do_inc(1'b0, 16'hFFFF, 16'd0, 16'd0, 16'd0);
    check("R4 wrap ch0_x", ch0_x, 16'hFFFF);
    do_inc(1'b1, 16'd2, 16'd1, 16'd0, 16'hFFFE);
    check("R4 ch0_z", ch0_z, 2);
    check("R4 ch0_w", ch0_w, 1);
    check("R4 ch1_w", ch1_w, 16'hFFFE);

    // R5 restore from saved copy, channel 0 only
    do_set(1'b0, 4'b0010, 16'd0, 16'd10, 16'd0, 16'd0);
    do_inc(1'b0, 16'd0, 16'd5, 16'd0, 16'd7);
    check("R5 pre ch0_y", ch0_y, 15);
    cr_vld = 1'b1; cr_sel = 1'b0; cr_chmask = 2'b01;
    tick();
    check("R5 ch0_y restored", ch0_y, 10);
    check("R5 ch1_y untouched", ch1_y, 7);

    // R6 transfer auto-increment from slot 2 (0xE4)
    xfer_vld = 1'b1; xfer_slot = 2'd2;
    tick();
    check("R6 ch0_y", ch0_y, 10);
    check("R6 ch0_z", ch0_z, 3);
    check("R6 ch1_y", ch1_y, 9);
    check("R6 ch1_z", ch1_z, 3);
    check("R6 ch0_x unchanged", ch0_x, 16'hFFFF);

    // R7 priority
    set_vld = 1'b1; set_sel = 1'b0; set_mask = 4'b0001; set_data = {48'd0, 16'd40};
    inc_vld = 1'b1; inc_sel = 1'b0; inc_data = {16'd1, 16'd1, 16'd1, 16'd1};
    xfer_vld = 1'b1; xfer_slot = 2'd2;
    tick();
    check("R7 set wins ch0_x", ch0_x, 40);
    check("R7 set wins ch0_y", ch0_y, 10);
    check("R7 set wins ch1_y", ch1_y, 9);
    inc_vld = 1'b1; inc_sel = 1'b1; inc_data = {16'd0, 16'd0, 16'd0, 16'd1};
    xfer_vld = 1'b1; xfer_slot = 2'd2;
    tick();
    check("R7 inc applied ch0_z", ch0_z, 4);
    check("R7 auto blocked ch1_z", ch1_z, 3);
    check("R7 auto blocked ch1_y", ch1_y, 9);
    tick();
    check("R7 idle hold ch0_x", ch0_x, 40);

    // R8 output address table
    foreach (OUT_TBL[k]) begin
      do_set(1'b0, 4'b1000, 16'd0, 16'd0, 16'd0, OUT_TBL[k][0][15:0]);
      do_set(1'b1, 4'b1100, 16'd0, 16'd0, OUT_TBL[k][1][15:0], OUT_TBL[k][2][15:0]);
      out_base = OUT_TBL[k][3];
      y_stride = OUT_TBL[k][4][15:0];
      z_stride = OUT_TBL[k][5][15:0];
      w_stride = OUT_TBL[k][6][15:0];
      out_fmt  = OUT_TBL[k][7][1:0];
      #1;
      check($sformatf("R8 row %0d", k), out_addr, OUT_TBL[k][8]);
    end

    // R9 input address, header skip and wrap
    in_base = 24'h100; in_offset = 16'h20; digest_size = 4'd0;
    in_limit = 24'hFFFFFF; fifo_size = 24'h40;
    #1 check("R9 no digest", in_addr, 24'h121);
    digest_size = 4'd2;
    #1 check("R9 digest 2", in_addr, 24'h123);
    digest_size = 4'd0; in_limit = 24'h120;
    #1 check("R9 wrap", in_addr, 24'hE1);
    in_base = 24'h11F; in_offset = 16'h0;
    #1 check("R9 at limit no wrap", in_addr, 24'h120);

    // R10 context counter
    ctx_log2 = 2'd2; xfer_slot = 2'd0;
    ctx_clr = 1'b1;
    tick();
    for (int n = 0; n < 5; n++) begin
      xfer_vld = 1'b1; xfer_ctx_auto = 1'b1;
      tick();
    end
    check("R10 four contexts", ctx_id, 1);
    ctx_log2 = 2'd0;
    xfer_vld = 1'b1;
    tick();
    check("R10 single context", ctx_id, 0);
    ctx_log2 = 2'd3; xfer_ctx_auto = 1'b0;
    xfer_vld = 1'b1;
    tick();
    check("R10 no auto flag", ctx_id, 0);
    xfer_ctx_auto = 1'b1; xfer_vld = 1'b1;
    tick();
    check("R10 advance", ctx_id, 1);
    xfer_vld = 1'b1; ctx_clr = 1'b1;
    tick();
    check("R10 clear wins", ctx_id, 0);

    finish_run();
  end

endmodule